// File: doc/BRIEF.md
# Bridge Overcurrent Fault and Retry Manager

This block sits between the analog protection comparators of a full-bridge motor driver and the gate-drive enable. It watches a digital overcurrent indication. When that indication stays high long enough, it shuts the bridge down and pulls an active-low fault line. The retry-select input chooses how the block recovers. In timed mode the block waits a fixed number of clock cycles with the bridge off, then re-enables it so that a short which is still present trips the block again. In hold mode the fault stays in force until the device enters standby or power-on reset is applied.

Over-temperature and supply-undervoltage indications are merged into the same bridge-off output. These two conditions act only while their flag is high. They leave no memory behind and never touch the fault line.

Top module: `ocp_fault_mgr`

## Requirements
- R1: While `por_n` is low, the block clears any fault asynchronously. With both condition flags low, `bridge_off` is 0 and `fault_n` is 1.
- R2: `oc_det` must be high at QUAL_CYCLES consecutive rising edges while the bridge is enabled and `standby` is low. From the last of those edges onward, `bridge_off` is 1 and `fault_n` is 0.
- R3: A run of `oc_det` highs shorter than QUAL_CYCLES, followed by a low, never raises a fault.
- R4: When `retry_hold` is 0 at the fault edge, `bridge_off` stays 1 and `fault_n` stays 0 for exactly RETRY_CYCLES further rising edges. At that edge both release together.
- R5: After a timed re-enable, qualification restarts from zero. A renewed overcurrent trips again after QUAL_CYCLES edges and restarts the full RETRY_CYCLES timeout.
- R6: When `retry_hold` is 1 at the fault edge, the fault holds indefinitely. Later changes of `retry_hold` have no effect on it.
- R7: `standby` high at a rising edge clears a held or timed fault at that edge. While `standby` is high, `oc_det` cannot raise a fault.
- R8: `tsd_flag` high drives `bridge_off` to 1 in the same cycle without changing `fault_n`. Once the flag drops, `bridge_off` follows the fault state only.
- R9: `uvlo_flag` high drives `bridge_off` to 1 in the same cycle without changing `fault_n`, and nothing of it is retained after it drops.
- R10: A pulse on `por_n` clears a held fault that `retry_hold` would otherwise keep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| oc_det | input | 1 | Overcurrent comparator indication, high when a short is sensed |
| retry_hold | input | 1 | 0 selects timed retry, 1 selects a held fault |
| standby | input | 1 | High while the device is in low-power standby |
| tsd_flag | input | 1 | Over-temperature indication, hysteresis applied upstream |
| uvlo_flag | input | 1 | Supply undervoltage indication |
| bridge_off | output | 1 | High disables all bridge switches |
| fault_n | output | 1 | Active-low overcurrent fault indication |

## Verification
A wrong qualification count moves the falling edge of `fault_n` earlier or later than the QUAL_CYCLES-th sampling edge. It also makes a short burst of `oc_det` raise a fault. A timer off by one shows as `fault_n` rising one edge early or late in timed mode. A stale qualification count after re-enable shows up within the next QUAL_CYCLES edges of a persistent short. A wrong mode capture or standby clear shows as `fault_n` staying low, or releasing, at the very next edge after `retry_hold` or `standby` changes.

// File: rtl/ocp_mgr_pkg.sv
package ocp_mgr_pkg;
   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_WAIT = 2'd1,
      ST_HOLD = 2'd2
   } fault_st_t;
endpackage

// File: rtl/ocp_qualifier.sv
module ocp_qualifier #(
   parameter int unsigned QUAL_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic oc_det,
   output logic trip
);
   localparam int unsigned QW = (QUAL_CYCLES > 1) ? $clog2(QUAL_CYCLES) : 1;

   if (QUAL_CYCLES < 1) begin : g_bad_qual
      $error("QUAL_CYCLES must be at least 1");
   end

   if (QUAL_CYCLES == 1) begin : g_direct
      assign trip = en & oc_det;
   end else begin : g_count
      localparam logic [QW-1:0] LAST = QW'(QUAL_CYCLES - 1);
      logic [QW-1:0] run_cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            run_cnt <= '0;
         else if (!en || !oc_det)
            run_cnt <= '0;
         else if (run_cnt != LAST)
            run_cnt <= run_cnt + 1'b1;
      end

      assign trip = en & oc_det & (run_cnt == LAST);

      // R3
      trip_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
         trip |-> $past(oc_det) && $past(en));
   end
endmodule

// File: rtl/ocp_retry_timer.sv
module ocp_retry_timer #(
   parameter int unsigned RETRY_CYCLES = 100000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);
   localparam int unsigned TW = (RETRY_CYCLES > 2) ? $clog2(RETRY_CYCLES) : 1;
   localparam logic [TW-1:0] LAST = TW'(RETRY_CYCLES - 1);

   if (RETRY_CYCLES < 2) begin : g_bad_retry
      $error("RETRY_CYCLES must be at least 2");
   end

   logic [TW-1:0] tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tick <= '0;
      else if (!run || done)
         tick <= '0;
      else
         tick <= tick + 1'b1;
   end

   assign done = run & (tick == LAST);

   // R4
   tick_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick <= LAST);
endmodule

// File: rtl/ocp_fault_mgr.sv
module ocp_fault_mgr
   import ocp_mgr_pkg::*;
#(
   parameter int unsigned QUAL_CYCLES  = 4,
   parameter int unsigned RETRY_CYCLES = 100000
) (
   input  logic clk,
   input  logic por_n,
   input  logic oc_det,
   input  logic retry_hold,
   input  logic standby,
   input  logic tsd_flag,
   input  logic uvlo_flag,
   output logic bridge_off,
   output logic fault_n
);
   fault_st_t state, state_nx;
   logic      oc_trip;
   logic      tmr_done;
   logic      qual_en;

   assign qual_en = (state == ST_RUN) & ~standby;

   ocp_qualifier #(.QUAL_CYCLES(QUAL_CYCLES)) qual_i (
      .clk    (clk),
      .rst_n  (por_n),
      .en     (qual_en),
      .oc_det (oc_det),
      .trip   (oc_trip)
   );

   ocp_retry_timer #(.RETRY_CYCLES(RETRY_CYCLES)) tmr_i (
      .clk   (clk),
      .rst_n (por_n),
      .run   (state == ST_WAIT),
      .done  (tmr_done)
   );

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_RUN:  if (oc_trip) state_nx = retry_hold ? ST_HOLD : ST_WAIT;
         ST_WAIT: if (standby || tmr_done) state_nx = ST_RUN;
         ST_HOLD: if (standby) state_nx = ST_RUN;
         default: state_nx = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
         state <= ST_RUN;
      else
         state <= state_nx;
   end

   assign fault_n    = (state == ST_RUN);
   assign bridge_off = ~fault_n | tsd_flag | uvlo_flag;

   // R2
   fault_entry_chk: assert property (@(posedge clk) disable iff (!por_n)
      $fell(fault_n) |-> $past(oc_trip));

   // R4
   timed_release_chk: assert property (@(posedge clk) disable iff (!por_n)
      $rose(fault_n) |-> $past(tmr_done) || $past(standby));

   // R6
   hold_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
      (state == ST_HOLD) && !standby |=> (state == ST_HOLD));

   // R7
   standby_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
      standby |=> fault_n);

   // R2
   fault_forces_off_chk: assert property (@(posedge clk) disable iff (!por_n)
      !fault_n |-> bridge_off);
endmodule

// File: tb/ocp_fault_mgr_tb.sv
module ocp_fault_mgr_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int QUAL  = 3;
   localparam int RETRY = 5;

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic oc_det = 1'b0, retry_hold = 1'b0, standby = 1'b0;
   logic tsd_flag = 1'b0, uvlo_flag = 1'b0;
   logic bridge_off, fault_n;

   int applied = 0;
   int errors  = 0;
   bit finished = 1'b0;

   logic [1:0] exp_q[$];
   string      tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   ocp_fault_mgr #(.QUAL_CYCLES(QUAL), .RETRY_CYCLES(RETRY)) dut_i (
      .clk(clk), .por_n(por_n), .oc_det(oc_det), .retry_hold(retry_hold),
      .standby(standby), .tsd_flag(tsd_flag), .uvlo_flag(uvlo_flag),
      .bridge_off(bridge_off), .fault_n(fault_n)
   );

   task automatic compare(input logic eoff, input logic efn, input string tag);
      applied++;
      if (bridge_off !== eoff || fault_n !== efn) begin
         errors++;
         $display("FAIL %s: off/fault_n = %b/%b, expected %b/%b",
                  tag, bridge_off, fault_n, eoff, efn);
      end
   endtask

   task automatic apply(input logic oc, input logic rh, input logic sb,
                        input logic tsd, input logic uv,
                        input logic eoff, input logic efn, input string tag);
      @(negedge clk);
      oc_det = oc; retry_hold = rh; standby = sb; tsd_flag = tsd; uvlo_flag = uv;
      exp_q.push_back({eoff, efn});
      tag_q.push_back(tag);
   endtask

   always @(posedge clk) begin
      #1;
      if (exp_q.size() != 0) begin
         logic [1:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         compare(e[1], e[0], t);
      end
   end

   task automatic drain();
      while (exp_q.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 3);
      compare(1'b0, 1'b1, "R1 reset");
      @(negedge clk);
      por_n = 1'b1;

      // R2 then R4: timed retry
      apply(1,0,0,0,0, 0,1, "R2 qual 1");
      apply(1,0,0,0,0, 0,1, "R2 qual 2");
      apply(1,0,0,0,0, 1,0, "R2 trip");
      for (int i = 0; i < RETRY-1; i++) apply(0,0,0,0,0, 1,0, "R4 waiting");
      apply(0,0,0,0,0, 0,1, "R4 release");

      // R3: short bursts
      apply(1,0,0,0,0, 0,1, "R3 burst");
      apply(1,0,0,0,0, 0,1, "R3 burst");
      apply(0,0,0,0,0, 0,1, "R3 gap");
      apply(1,0,0,0,0, 0,1, "R3 burst");
      apply(1,0,0,0,0, 0,1, "R3 burst");
      apply(0,0,0,0,0, 0,1, "R3 gap");

      // R5: persistent short
      apply(1,0,0,0,0, 0,1, "R5 first qual");
      apply(1,0,0,0,0, 0,1, "R5 first qual");
      apply(1,0,0,0,0, 1,0, "R5 first trip");
      for (int i = 0; i < RETRY-1; i++) apply(1,0,0,0,0, 1,0, "R5 first wait");
      apply(1,0,0,0,0, 0,1, "R5 re-enable");
      apply(1,0,0,0,0, 0,1, "R5 requal");
      apply(1,0,0,0,0, 0,1, "R5 requal");
      apply(1,0,0,0,0, 1,0, "R5 second trip");
      for (int i = 0; i < RETRY-1; i++) apply(0,0,0,0,0, 1,0, "R5 second wait");
      apply(0,0,0,0,0, 0,1, "R5 second release");

      // R6: held fault, then R7 standby clear
      apply(1,1,0,0,0, 0,1, "R6 qual");
      apply(1,1,0,0,0, 0,1, "R6 qual");
      apply(1,1,0,0,0, 1,0, "R6 trip");
      for (int i = 0; i < 2*RETRY; i++) apply(0,1,0,0,0, 1,0, "R6 held");
      for (int i = 0; i < 3; i++) apply(0,0,0,0,0, 1,0, "R6 mode change ignored");
      apply(0,0,1,0,0, 0,1, "R7 standby clears hold");
      apply(0,0,0,0,0, 0,1, "R7 after standby");

      // R7: standby suppresses qualification and clears a timed fault
      for (int i = 0; i < QUAL+1; i++) apply(1,0,1,0,0, 0,1, "R7 suppressed");
      apply(0,0,0,0,0, 0,1, "R7 suppressed end");
      apply(1,0,0,0,0, 0,1, "R7 qual");
      apply(1,0,0,0,0, 0,1, "R7 qual");
      apply(1,0,0,0,0, 1,0, "R7 timed trip");
      apply(0,0,0,0,0, 1,0, "R7 waiting");
      apply(0,0,1,0,0, 0,1, "R7 standby clears wait");
      apply(0,0,0,0,0, 0,1, "R7 idle");

      // R8 / R9: non-latching conditions
      apply(0,0,0,1,0, 1,1, "R8 thermal off");
      apply(0,0,0,1,0, 1,1, "R8 thermal off");
      apply(0,0,0,0,0, 0,1, "R8 thermal release");
      apply(0,0,0,0,1, 1,1, "R9 uvlo off");
      apply(0,0,0,0,0, 0,1, "R9 uvlo release");
      apply(1,1,0,0,0, 0,1, "R8 qual");
      apply(1,1,0,0,0, 0,1, "R8 qual");
      apply(1,1,0,0,0, 1,0, "R8 held trip");
      apply(0,1,0,1,0, 1,0, "R8 thermal over hold");
      apply(0,1,0,0,0, 1,0, "R8 hold remains");

      // R10: power-on reset clears the hold
      drain();
      por_n = 1'b0;
      #1;
      compare(1'b0, 1'b1, "R10 por clears");
      @(negedge clk);
      por_n = 1'b1;
      apply(0,1,0,0,0, 0,1, "R10 after por");
      drain();

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
         $finish;
      end
   end
endmodule